// File: doc/BRIEF.md
# Programmable Resolution Time Tag Counter

This block keeps a 16-bit time reference for a serial data bus terminal. A 1 MHz tick goes through a prescaler whose period can be set from 2 to 64 microseconds, and the counter advances once per period. The host can read the counter at any time, overwrite it, or move it into a test mode in which only a software step strobe advances it.

Two bus mode-command events also act on the counter, each enabled on its own. A synchronize event that carries no data clears it. A synchronize event that carries a data word loads that word. Each time the counter wraps from all ones to zero, the block gives a one-cycle rollover pulse and sets a sticky status bit. Start-of-message and end-of-message strobes each latch the current count into their own capture register. The message stack logic then reads those registers.

Top module: `time_tag_counter`

## Requirements
- R1: After reset, the count, both capture registers, the rollover pulse and the rollover status are all zero.
- R2: A host write loads `host_wdata` into the count at the next clock edge. The write wins over an increment, whether tick or step, that falls in the same cycle. The prescaler keeps running through that cycle.
- R3: `res_sel` value n selects a period of 2^(n+1) ticks per count for n = 0..5. Values 6 and 7 behave as 5 (64 ticks). Starting from a cleared prescaler, k ticks give k / period counts.
- R4: A change in the effective resolution clears the prescaler. Any tick in the cycle of the change is discarded, so the next count needs a full new period.
- R5: While `sw_mode` is 1, ticks have no effect on the count and the prescaler is held clear. Each `sw_step` pulse adds one to the count. When `sw_mode` is 0, `sw_step` is ignored.
- R6: `soft_clr` clears the count and the prescaler. It takes priority over every other update.
- R7: `sync_nodata` clears the count when `clr_on_sync` is 1. When `clr_on_sync` is 0 it has no effect.
- R8: `sync_data_ev` loads `sync_data` into the count when `load_on_sync` is 1. When `load_on_sync` is 0 it has no effect. If both synchronize events are enabled and arrive together, the load wins.
- R9: An increment from 16'hFFFF gives a count of 0 and a `roll_pulse` that lasts exactly one cycle. The same edge sets `roll_sts`, which stays set until `roll_ack`. If a wrap and an ack fall in the same cycle, the status stays set.
- R10: `som` latches into `cap_som`, and `eom` into `cap_eom`, the count value present before that clock edge's update.
- R11: Update priority, from highest to lowest: soft clear, host write, synchronize load, synchronize clear, increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| res_sel | input | 3 | Resolution select, 2^(n+1) ticks per count |
| sw_mode | input | 1 | Software-step test mode |
| sw_step | input | 1 | Software increment strobe |
| soft_clr | input | 1 | Clears count and prescaler |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write value |
| host_rdata | output | 16 | Current count |
| clr_on_sync | input | 1 | Enable clear on synchronize without data |
| load_on_sync | input | 1 | Enable load on synchronize with data |
| sync_nodata | input | 1 | Synchronize-without-data event |
| sync_data_ev | input | 1 | Synchronize-with-data event |
| sync_data | input | 16 | Data word of the synchronize event |
| som | input | 1 | Start-of-message capture strobe |
| eom | input | 1 | End-of-message capture strobe |
| cap_som | output | 16 | Count captured at start of message |
| cap_eom | output | 16 | Count captured at end of message |
| roll_pulse | output | 1 | One-cycle rollover pulse |
| roll_sts | output | 1 | Sticky rollover status |
| roll_ack | input | 1 | Clears rollover status |

## Verification
The assertions assume that every strobe and event input is a synchronous single-cycle pulse with a defined value after reset. They do not assume that events are mutually exclusive, so the checks on same-cycle priority still hold. The stimulus drives every input one time unit after the rising edge and returns strobes to zero after one cycle. It then applies simultaneous write, tick, synchronize, soft-clear and acknowledge pulses on purpose, so that each ordering rule is reached. The resolution sweep runs every select value from a cleared prescaler. The expected count is computed as the integer quotient of ticks by period.

// File: rtl/time_tag_counter.sv
module time_tag_counter #(
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic [SEL_W-1:0] res_sel,
  input  logic             sw_mode,
  input  logic             sw_step,
  input  logic             soft_clr,
  input  logic             host_wr,
  input  logic [CNT_W-1:0] host_wdata,
  output logic [CNT_W-1:0] host_rdata,
  input  logic             clr_on_sync,
  input  logic             load_on_sync,
  input  logic             sync_nodata,
  input  logic             sync_data_ev,
  input  logic [CNT_W-1:0] sync_data,
  input  logic             som,
  input  logic             eom,
  output logic [CNT_W-1:0] cap_som,
  output logic [CNT_W-1:0] cap_eom,
  output logic             roll_pulse,
  output logic             roll_sts,
  input  logic             roll_ack
);
  localparam int PRE_W = MAX_SEL + 1;
  localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(MAX_SEL);

  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [SEL_W-1:0] sel_q;

  wire [SEL_W-1:0] sel_eff  = (res_sel > SEL_TOP) ? SEL_TOP : res_sel;
  wire [PRE_W-1:0] pre_last = {PRE_W{1'b1}} >> (SEL_TOP - sel_eff);
  wire             sel_chg  = sel_eff != sel_q;
  wire             hw_tick  = tick_us & ~sw_mode & ~sel_chg;
  wire             pre_end  = hw_tick & (pre_q == pre_last);
  wire             inc      = sw_mode ? sw_step : pre_end;
  wire             do_load  = sync_data_ev & load_on_sync;
  wire             do_clr   = sync_nodata & clr_on_sync;
  wire             overrule = soft_clr | host_wr | do_load | do_clr;
  wire             wrap     = ~overrule & inc & (&cnt_q);

  assign host_rdata = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= sel_eff;
      if (soft_clr || sel_chg || sw_mode)
        pre_q <= '0;
      else if (hw_tick)
        pre_q <= pre_end ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (soft_clr)  cnt_q <= '0;
    else if (host_wr)   cnt_q <= host_wdata;
    else if (do_load)   cnt_q <= sync_data;
    else if (do_clr)    cnt_q <= '0;
    else if (inc)       cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_som    <= '0;
      cap_eom    <= '0;
      roll_pulse <= 1'b0;
      roll_sts   <= 1'b0;
    end else begin
      if (som) cap_som <= cnt_q;
      if (eom) cap_eom <= cnt_q;
      roll_pulse <= wrap;
      roll_sts   <= wrap | (roll_sts & ~roll_ack);
    end
  end
endmodule

// File: rtl/time_tag_counter_chk.sv
module time_tag_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_mode,
  input logic             sw_step,
  input logic             tick_us,
  input logic             soft_clr,
  input logic             host_wr,
  input logic [CNT_W-1:0] host_wdata,
  input logic [CNT_W-1:0] host_rdata,
  input logic             clr_on_sync,
  input logic             load_on_sync,
  input logic             sync_nodata,
  input logic             sync_data_ev,
  input logic             som,
  input logic [CNT_W-1:0] cap_som,
  input logic             roll_pulse,
  input logic             roll_sts,
  input logic             roll_ack
);
  wire quiet = ~soft_clr & ~host_wr & ~(sync_nodata & clr_on_sync) &
               ~(sync_data_ev & load_on_sync);

  assert_soft_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> host_rdata == '0);

  assert_host_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !soft_clr) |=> host_rdata == $past(host_wdata));

  assert_sw_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_mode && !sw_step && quiet) |=> $stable(host_rdata));

  assert_step_at_most_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> (host_rdata == $past(host_rdata)) ||
              (host_rdata == $past(host_rdata) + 1'b1));

  assert_wrap_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(roll_pulse) |-> (host_rdata == '0) && ($past(host_rdata) == '1));

  assert_wrap_sets_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    roll_pulse |-> roll_sts);

  assert_som_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    som |=> cap_som == $past(host_rdata));
endmodule

bind time_tag_counter time_tag_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .sw_step(sw_step),
  .tick_us(tick_us), .soft_clr(soft_clr), .host_wr(host_wr),
  .host_wdata(host_wdata), .host_rdata(host_rdata),
  .clr_on_sync(clr_on_sync), .load_on_sync(load_on_sync),
  .sync_nodata(sync_nodata), .sync_data_ev(sync_data_ev), .som(som),
  .cap_som(cap_som), .roll_pulse(roll_pulse), .roll_sts(roll_sts),
  .roll_ack(roll_ack));

// File: tb/time_tag_counter_tb.sv
`timescale 1ns/1ps
module time_tag_counter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 0, sw_mode = 0, sw_step = 0, soft_clr = 0, host_wr = 0;
  logic [2:0] res_sel = 0;
  logic [15:0] host_wdata = 0, sync_data = 0;
  logic clr_on_sync = 0, load_on_sync = 0, sync_nodata = 0, sync_data_ev = 0;
  logic som = 0, eom = 0, roll_ack = 0;
  logic [15:0] host_rdata, cap_som, cap_eom;
  logic roll_pulse, roll_sts;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  time_tag_counter u_dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .res_sel(res_sel),
    .sw_mode(sw_mode), .sw_step(sw_step), .soft_clr(soft_clr),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .clr_on_sync(clr_on_sync), .load_on_sync(load_on_sync),
    .sync_nodata(sync_nodata), .sync_data_ev(sync_data_ev),
    .sync_data(sync_data), .som(som), .eom(eom), .cap_som(cap_som),
    .cap_eom(cap_eom), .roll_pulse(roll_pulse), .roll_sts(roll_sts),
    .roll_ack(roll_ack));

  task automatic cyc;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all;
    soft_clr = 1; cyc; soft_clr = 0;
  endtask

  task automatic wr(input logic [15:0] v);
    host_wr = 1; host_wdata = v; cyc; host_wr = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    #1;
    chk("R1 count", host_rdata, 0);
    cyc; cyc; rst_n = 1; cyc;
    chk("R1 count", host_rdata, 0);
    chk("R1 cap_som", cap_som, 0);
    chk("R1 cap_eom", cap_eom, 0);
    chk("R1 roll_pulse", roll_pulse, 0);
    chk("R1 roll_sts", roll_sts, 0);

    // R3: sweep every select value from a cleared prescaler
    for (int s = 0; s < 8; s++) begin
      int per;
      per = 2 << ((s > 5) ? 5 : s);
      res_sel = 3'(s); cyc;
      clear_all;
      for (int k = 1; k <= 140; k++) begin
        tick_us = 1; cyc; tick_us = 0;
        chk("R3 resolution", host_rdata, k / per);
      end
    end

    // R4: change of resolution clears prescaler, tick in that cycle dropped
    res_sel = 0; cyc; clear_all;
    tick_us = 1; cyc;
    res_sel = 1; cyc;
    for (int k = 1; k <= 3; k++) begin
      cyc;
      chk("R4 no early count", host_rdata, 0);
    end
    cyc; tick_us = 0;
    chk("R4 full period", host_rdata, 1);

    // R5: software mode
    clear_all; sw_mode = 1;
    tick_us = 1;
    for (int k = 0; k < 10; k++) cyc;
    tick_us = 0;
    chk("R5 ticks ignored", host_rdata, 0);
    for (int k = 1; k <= 5; k++) begin
      sw_step = 1; cyc; sw_step = 0;
      chk("R5 step", host_rdata, k);
    end
    sw_mode = 0;
    sw_step = 1; cyc; sw_step = 0;
    chk("R5 step ignored off", host_rdata, 5);

    // R2: host write wins over tick
    res_sel = 0; cyc; clear_all;
    tick_us = 1; cyc;
    host_wr = 1; host_wdata = 16'h1234; cyc; host_wr = 0;
    chk("R2 write wins", host_rdata, 16'h1234);
    cyc; chk("R2 prescaler ran", host_rdata, 16'h1234);
    cyc; tick_us = 0;
    chk("R2 next count", host_rdata, 16'h1235);

    // R6 / R11: soft clear beats host write
    host_wr = 1; host_wdata = 16'h5555; soft_clr = 1; cyc;
    host_wr = 0; soft_clr = 0;
    chk("R6 R11 clear priority", host_rdata, 0);

    // R7 / R8
    wr(16'h0077);
    sync_nodata = 1; cyc; sync_nodata = 0;
    chk("R7 disabled", host_rdata, 16'h0077);
    clr_on_sync = 1;
    sync_nodata = 1; cyc; sync_nodata = 0;
    chk("R7 clear", host_rdata, 0);
    sync_data = 16'hABCD;
    sync_data_ev = 1; cyc; sync_data_ev = 0;
    chk("R8 disabled", host_rdata, 0);
    load_on_sync = 1;
    sync_data_ev = 1; cyc; sync_data_ev = 0;
    chk("R8 load", host_rdata, 16'hABCD);
    wr(16'h0010);
    sync_data = 16'h0BEE; sync_data_ev = 1; sync_nodata = 1; cyc;
    sync_data_ev = 0; sync_nodata = 0;
    chk("R8 R11 load beats clear", host_rdata, 16'h0BEE);
    host_wr = 1; host_wdata = 16'h0321; sync_data_ev = 1; cyc;
    host_wr = 0; sync_data_ev = 0;
    chk("R11 write beats load", host_rdata, 16'h0321);

    // R9: rollover
    wr(16'hFFFE); sw_mode = 1;
    sw_step = 1; cyc; sw_step = 0;
    chk("R9 no early pulse", roll_pulse, 0);
    sw_step = 1; cyc; sw_step = 0;
    chk("R9 wrap value", host_rdata, 0);
    chk("R9 pulse", roll_pulse, 1);
    chk("R9 status", roll_sts, 1);
    cyc;
    chk("R9 pulse one cycle", roll_pulse, 0);
    chk("R9 status sticky", roll_sts, 1);
    roll_ack = 1; cyc; roll_ack = 0;
    chk("R9 ack", roll_sts, 0);
    wr(16'hFFFF);
    sw_step = 1; roll_ack = 1; cyc; sw_step = 0; roll_ack = 0;
    chk("R9 set beats ack", roll_sts, 1);

    // R10: capture before update
    wr(16'h0100);
    som = 1; sw_step = 1; cyc; som = 0; sw_step = 0;
    chk("R10 som", cap_som, 16'h0100);
    chk("R10 count", host_rdata, 16'h0101);
    eom = 1; cyc; eom = 0;
    chk("R10 eom", cap_eom, 16'h0101);
    chk("R10 som held", cap_som, 16'h0100);
    sw_mode = 0;

    finish_run();
  end
endmodule